// File: doc/BRIEF.md
# Operand-Tracking Computation Unit Controller

This block sits in front of one execution unit and follows every operation from the moment it is issued until its result has been written back. On an accepted issue it latches the operation fields: opcode, invert-A flag, immediate value, immediate-valid flag and zero-A flag. From the next cycle it holds `busy` high. It then asks for each source operand through a separate release/go pair per port, and it captures an operand only in the cycle where that port's go is high.

Some operands need no request. A zero-forced A, an immediate-substituted B and any port masked by the live read mask are never requested, and they take a fixed value instead. Once every requested operand is in, the controller presents the operands to the execution unit with a valid/ready handshake. It captures the unit's result into a holding register and then requests a write-back slot through a release/go pair. `busy` falls only after the write has been accepted, so a result is never dropped.

Top module: `op_track_unit`

## Requirements
- R1: An issue sampled while `busy` is low makes `busy` high on the next cycle. An issue while `busy` is high is ignored: it starts no second operation and leaves the latched opcode and all handshake counts unchanged.
- R2: `busy` stays high through the cycle in which `wrGo` is accepted with `wrRel` high, and it is low on the following cycle.
- R3: Each needed source port raises its own `rdRel` bit and keeps it high until that port's `rdGo` is seen. The port's `srcData` slice (port i at bits i*WIDTH upward) is captured only in that go cycle. Go may come in the same cycle the release is first visible or any number of cycles later, and ports may complete in any order.
- R4: With zero-A set at issue, `rdRel[0]` never rises and operand A is zero.
- R5: With immediate-valid set at issue, `rdRel[1]` never rises and operand B is the immediate latched at issue.
- R6: A set `rdMask` bit (bit i for port i, held from the issue cycle until `busy` falls) keeps that port's `rdRel` low, and that operand reads as zero. This overrides the immediate on port 1.
- R7: With invert-A set, operand A seen by the execution unit is the bitwise inverse of the value left after zero-forcing or masking (for example 5 inverted plus 2 gives 65532 at 16 bits).
- R8: Opcode, invert-A, immediate, immediate-valid and zero-A are used only as sampled in the issue cycle. Changing them afterwards has no effect on the operation.
- R9: `exInValid` rises after the last needed operand is captured and stays high until `exInReady`, with `exSrc` stable meanwhile.
- R10: The result is taken when `exOutValid` meets `exOutReady`. `wrRel` then rises and holds with `resultData` stable until `wrGo`. An execution unit whose output valid follows its input valid in the same cycle still yields exactly one write handshake.
- R11: Per operation, each needed port completes exactly one read handshake, and the execution input and the write port each complete exactly one handshake.
- R12: After reset, `busy`, `rdRel`, `wrRel` and `exInValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Issue strobe for a new operation |
| opCode | input | OPW | Opcode sampled at issue |
| invertA | input | 1 | Invert operand A |
| immData | input | WIDTH | Immediate value |
| immValid | input | 1 | Use the immediate as operand B |
| zeroA | input | 1 | Force operand A to zero |
| rdMask | input | NSRC | Per-port read mask, held while busy |
| busy | output | 1 | Operation in flight |
| rdRel | output | NSRC | Per-port operand request |
| rdGo | input | NSRC | Per-port operand grant, data valid |
| srcData | input | NSRC*WIDTH | Operand data, port i at slice i |
| exOpCode | output | OPW | Latched opcode to the execution unit |
| exSrc | output | NSRC*WIDTH | Operands to the execution unit |
| exInValid | output | 1 | Operands valid to the execution unit |
| exInReady | input | 1 | Execution unit accepts operands |
| exOutValid | input | 1 | Execution unit result valid |
| exOutData | input | WIDTH | Execution unit result |
| exOutReady | output | 1 | Controller takes the result |
| wrRel | output | 1 | Write-back request |
| wrGo | input | 1 | Write-back grant |
| resultData | output | WIDTH | Result presented for write-back |

## Verification
The bench covers zero-delay grants, reversed and simultaneous operand arrival, and mixes of zero-A, immediate and mask on the same operation. A controller that waits one cycle too long or re-requests a port would show a second release edge or a miscounted handshake. It would also leave a suppressed port requesting forever and hang. The bench scrambles the decode fields right after issue, so a design that reads them live produces a wrong operand. It also pulses issue while busy, so a design that accepts that issue is caught by a changed opcode or extra handshakes. An execution model that answers combinationally targets a design that writes the result twice or loses it when input and output valid coincide.

// File: rtl/op_track_pkg.sv
package op_track_pkg;
  localparam int MAX_SRC = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_EXEC,
    ST_RESULT,
    ST_WRITE
  } trackState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic               latchIssue;
    logic [MAX_SRC-1:0] capture;
    logic               takeResult;
  } dpStrobe_t;
endpackage

// File: rtl/op_track_ctrl.sv
module op_track_ctrl
  import op_track_pkg::*;
#(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            issueValid,
  input  logic            zeroA,
  input  logic            immValid,
  input  logic [NSRC-1:0] rdMask,
  input  logic [NSRC-1:0] rdGo,
  input  logic            exInReady,
  input  logic            exOutValid,
  input  logic            wrGo,
  output logic            busy,
  output logic [NSRC-1:0] rdRel,
  output logic            exInValid,
  output logic            exOutReady,
  output logic            wrRel,
  output dpStrobe_t       strobe
);
  trackState_t state, stateNext;
  logic [NSRC-1:0] pending, need, grant, remaining;
  logic issueTake;

  always_comb begin
    need    = '1;
    need[0] = ~zeroA;
    need[1] = ~immValid;
  end

  assign issueTake  = (state == ST_IDLE) && issueValid;
  assign rdRel      = (state == ST_READ) ? (pending & ~rdMask) : '0;
  assign grant      = rdRel & rdGo;
  assign remaining  = pending & ~grant & ~rdMask;
  assign exInValid  = (state == ST_EXEC);
  assign exOutReady = (state == ST_RESULT) || ((state == ST_EXEC) && exInReady);
  assign wrRel      = (state == ST_WRITE);
  assign busy       = (state != ST_IDLE);

  always_comb begin
    strobe                      = '0;
    strobe.latchIssue           = issueTake;
    strobe.capture[NSRC-1:0]    = grant;
    strobe.takeResult           = exOutReady && exOutValid;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (issueValid) stateNext = ST_READ;
      ST_READ:   if (remaining == '0) stateNext = ST_EXEC;
      ST_EXEC:   if (exInReady) stateNext = exOutValid ? ST_WRITE : ST_RESULT;
      ST_RESULT: if (exOutValid) stateNext = ST_WRITE;
      ST_WRITE:  if (wrGo) stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pending <= '0;
    end else begin
      state <= stateNext;
      if (issueTake) pending <= need;
      else if (state == ST_READ) pending <= pending & ~grant;
    end
  end
endmodule

// File: rtl/op_track_dpath.sv
module op_track_dpath
  import op_track_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int NSRC  = 3,
  parameter int OPW   = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strobe,
  input  logic [OPW-1:0]       opCode,
  input  logic                 invertA,
  input  logic [WIDTH-1:0]     immData,
  input  logic                 immValid,
  input  logic                 maskB,
  input  logic [NSRC*WIDTH-1:0] srcData,
  input  logic [WIDTH-1:0]     exOutData,
  output logic [OPW-1:0]       exOpCode,
  output logic [NSRC*WIDTH-1:0] exSrc,
  output logic [WIDTH-1:0]     resultData
);
  logic [OPW-1:0]   opReg;
  logic             invReg;
  logic [WIDTH-1:0] srcReg [NSRC];
  logic [WIDTH-1:0] resReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg  <= '0;
      invReg <= 1'b0;
      resReg <= '0;
    end else begin
      if (strobe.latchIssue) begin
        opReg  <= opCode;
        invReg <= invertA;
      end
      if (strobe.takeResult) resReg <= exOutData;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic [WIDTH-1:0] issueVal;
    if (i == 1) begin : g_imm
      assign issueVal = (immValid && !maskB) ? immData : '0;
    end else begin : g_zero
      assign issueVal = '0;
    end

    always_ff @(posedge clk) begin
      if (!rstN) srcReg[i] <= '0;
      else if (strobe.latchIssue) srcReg[i] <= issueVal;
      else if (strobe.capture[i]) srcReg[i] <= srcData[i*WIDTH +: WIDTH];
    end

    if (i == 0) begin : g_inv
      assign exSrc[i*WIDTH +: WIDTH] = invReg ? ~srcReg[i] : srcReg[i];
    end else begin : g_pass
      assign exSrc[i*WIDTH +: WIDTH] = srcReg[i];
    end
  end

  assign exOpCode   = opReg;
  assign resultData = resReg;
endmodule

// File: rtl/op_track_unit.sv
module op_track_unit
  import op_track_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int NSRC  = 3,
  parameter int OPW   = 7
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  issueValid,
  input  logic [OPW-1:0]        opCode,
  input  logic                  invertA,
  input  logic [WIDTH-1:0]      immData,
  input  logic                  immValid,
  input  logic                  zeroA,
  input  logic [NSRC-1:0]       rdMask,
  output logic                  busy,
  output logic [NSRC-1:0]       rdRel,
  input  logic [NSRC-1:0]       rdGo,
  input  logic [NSRC*WIDTH-1:0] srcData,
  output logic [OPW-1:0]        exOpCode,
  output logic [NSRC*WIDTH-1:0] exSrc,
  output logic                  exInValid,
  input  logic                  exInReady,
  input  logic                  exOutValid,
  input  logic [WIDTH-1:0]      exOutData,
  output logic                  exOutReady,
  output logic                  wrRel,
  input  logic                  wrGo,
  output logic [WIDTH-1:0]      resultData
);
  dpStrobe_t strobe;

  op_track_ctrl #(.NSRC(NSRC)) u_ctrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .zeroA(zeroA),
    .immValid(immValid), .rdMask(rdMask), .rdGo(rdGo),
    .exInReady(exInReady), .exOutValid(exOutValid), .wrGo(wrGo),
    .busy(busy), .rdRel(rdRel), .exInValid(exInValid),
    .exOutReady(exOutReady), .wrRel(wrRel), .strobe(strobe)
  );

  op_track_dpath #(.WIDTH(WIDTH), .NSRC(NSRC), .OPW(OPW)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opCode(opCode),
    .invertA(invertA), .immData(immData), .immValid(immValid),
    .maskB(rdMask[1]), .srcData(srcData), .exOutData(exOutData),
    .exOpCode(exOpCode), .exSrc(exSrc), .resultData(resultData)
  );
endmodule

// File: rtl/op_track_checker.sv
module op_track_checker #(
  parameter int WIDTH = 16,
  parameter int NSRC  = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  issueValid,
  input logic                  busy,
  input logic [NSRC-1:0]       rdRel,
  input logic [NSRC-1:0]       rdMask,
  input logic                  exInValid,
  input logic                  exInReady,
  input logic [NSRC*WIDTH-1:0] exSrc,
  input logic                  wrRel,
  input logic                  wrGo,
  input logic [WIDTH-1:0]      resultData
);
  assert_busy_rise_R1: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !busy) |=> busy);

  assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(wrRel && wrGo)) |=> busy);

  assert_busy_fall_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrRel && wrGo) |=> !busy);

  assert_rel_in_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|rdRel) |-> busy);

  assert_mask_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|rdMask) |-> ((rdRel & rdMask) == '0));

  assert_exin_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (exInValid && !exInReady) |=> (exInValid && $stable(exSrc)));

  assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrRel && !wrGo) |=> (wrRel && $stable(resultData)));

  assert_single_phase_R11: assert property (@(posedge clk) disable iff (!rstN)
    wrRel |-> (!exInValid && rdRel == '0));
endmodule

bind op_track_unit op_track_checker #(.WIDTH(WIDTH), .NSRC(NSRC)) u_check (
  .clk(clk), .rstN(rstN), .issueValid(issueValid), .busy(busy),
  .rdRel(rdRel), .rdMask(rdMask), .exInValid(exInValid),
  .exInReady(exInReady), .exSrc(exSrc), .wrRel(wrRel), .wrGo(wrGo),
  .resultData(resultData)
);

// File: tb/op_track_unit_bench.sv
`timescale 1ns/1ps
module op_track_unit_bench;
  localparam int W  = 16;
  localparam int N  = 3;
  localparam int OW = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic          issueValid = 0;
  logic [OW-1:0] opCode = '0;
  logic          invertA = 0;
  logic [W-1:0]  immData = '0;
  logic          immValid = 0;
  logic          zeroA = 0;
  logic [N-1:0]  rdMask = '0;
  logic [N-1:0]  rdGo = '0;
  logic [N*W-1:0] srcData = '0;
  logic          wrGo = 0;
  logic          busy, exInValid, exOutReady, wrRel;
  logic [N-1:0]  rdRel;
  logic [OW-1:0] exOpCode;
  logic [N*W-1:0] exSrc;
  logic [W-1:0]  resultData;
  logic          exInReady, exOutValid;
  logic [W-1:0]  exOutData;

  op_track_unit #(.WIDTH(W), .NSRC(N), .OPW(OW)) u_op_track_unit (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .opCode(opCode),
    .invertA(invertA), .immData(immData), .immValid(immValid), .zeroA(zeroA),
    .rdMask(rdMask), .busy(busy), .rdRel(rdRel), .rdGo(rdGo),
    .srcData(srcData), .exOpCode(exOpCode), .exSrc(exSrc),
    .exInValid(exInValid), .exInReady(exInReady), .exOutValid(exOutValid),
    .exOutData(exOutData), .exOutReady(exOutReady), .wrRel(wrRel),
    .wrGo(wrGo), .resultData(resultData)
  );

  // execution unit model: sum of the three operands
  logic combMode = 0;
  logic mBusy = 0;
  logic [1:0] mCnt = '0;
  logic [W-1:0] mRes = '0;
  logic [N*W-1:0] seenSrc = '0;
  logic [OW-1:0] seenOp = '0;
  int accCnt = 0;

  function automatic logic [W-1:0] sum3(input logic [N*W-1:0] s);
    return s[W-1:0] + s[2*W-1:W] + s[3*W-1:2*W];
  endfunction

  assign exInReady  = combMode ? 1'b1 : !mBusy;
  assign exOutValid = combMode ? exInValid : (mBusy && mCnt == 2'd0);
  assign exOutData  = combMode ? sum3(exSrc) : mRes;

  always @(posedge clk) begin
    if (exInValid && exInReady) begin
      seenSrc <= exSrc;
      seenOp  <= exOpCode;
      accCnt  <= accCnt + 1;
    end
    if (!rstN) mBusy <= 1'b0;
    else if (!combMode) begin
      if (!mBusy && exInValid) begin
        mBusy <= 1'b1;
        mCnt  <= 2'd2;
        mRes  <= sum3(exSrc);
      end else if (mBusy && mCnt != 2'd0) mCnt <= mCnt - 2'd1;
      else if (mBusy && exOutReady) mBusy <= 1'b0;
    end
  end

  // release edge counters
  int relRise [N];
  int wrRise = 0;
  logic [N-1:0] prevRel = '0;
  logic prevWr = 0;
  initial for (int i = 0; i < N; i++) relRise[i] = 0;
  always @(negedge clk) begin
    for (int i = 0; i < N; i++) if (rdRel[i] && !prevRel[i]) relRise[i] = relRise[i] + 1;
    if (wrRel && !prevWr) wrRise = wrRise + 1;
    prevRel = rdRel;
    prevWr  = wrRel;
  end

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic serveRead(input int idx, input int dly, input logic [W-1:0] v);
    while (!rdRel[idx]) @(negedge clk);
    repeat (dly) @(negedge clk);
    check(rdRel[idx] == 1'b1, "R3", "release held until go", rdRel[idx], 1);
    rdGo[idx] = 1'b1;
    srcData[idx*W +: W] = v;
    @(negedge clk);
    rdGo[idx] = 1'b0;
    srcData[idx*W +: W] = ~v;
    check(rdRel[idx] == 1'b0, "R3", "release drops after go", rdRel[idx], 0);
  endtask

  task automatic serveWrite(input int dly, input logic [W-1:0] exp);
    while (!wrRel) @(negedge clk);
    repeat (dly) @(negedge clk);
    check(resultData == exp, "R10", "result in go cycle", resultData, exp);
    check(busy == 1'b1, "R2", "busy high in go cycle", busy, 1);
    wrGo = 1'b1;
    @(negedge clk);
    wrGo = 1'b0;
    check(busy == 1'b0, "R2", "busy low after write", busy, 0);
    check(wrRel == 1'b0, "R10", "write release drops", wrRel, 0);
  endtask

  task automatic runOp(input string name, input logic [W-1:0] a, b, c,
                       input logic [OW-1:0] opc, input bit inv,
                       input logic [W-1:0] imm, input bit immV, input bit zA,
                       input logic [N-1:0] mask, input int d0, d1, d2, dw,
                       input bit comb, input bit poke);
    logic [W-1:0] eA, eB, eC, eR;
    bit n0, n1, n2;
    int r0, r1, r2, w0, a0;
    eA = (zA || mask[0]) ? '0 : a;
    if (inv) eA = ~eA;
    eB = mask[1] ? '0 : (immV ? imm : b);
    eC = mask[2] ? '0 : c;
    eR = eA + eB + eC;
    n0 = !zA && !mask[0];
    n1 = !immV && !mask[1];
    n2 = !mask[2];
    combMode = comb;
    r0 = relRise[0]; r1 = relRise[1]; r2 = relRise[2]; w0 = wrRise; a0 = accCnt;
    @(negedge clk);
    opCode = opc; invertA = inv; immData = imm; immValid = immV; zeroA = zA;
    rdMask = mask; issueValid = 1'b1;
    @(negedge clk);
    issueValid = 1'b0;
    check(busy == 1'b1, "R1", {name, ": busy after issue"}, busy, 1);
    opCode = ~opc; invertA = ~inv; immData = ~imm; immValid = ~immV; zeroA = ~zA;
    fork
      begin if (n0) serveRead(0, d0, a); end
      begin if (n1) serveRead(1, d1, b); end
      begin if (n2) serveRead(2, d2, c); end
      serveWrite(dw, eR);
      begin
        if (poke) begin
          opCode = 7'h55; issueValid = 1'b1;
          @(negedge clk);
          issueValid = 1'b0;
        end
      end
    join
    check(seenSrc[W-1:0] == eA, "R7", {name, ": operand A"}, seenSrc[W-1:0], eA);
    check(seenSrc[2*W-1:W] == eB, "R5", {name, ": operand B"}, seenSrc[2*W-1:W], eB);
    check(seenSrc[3*W-1:2*W] == eC, "R6", {name, ": operand C"}, seenSrc[3*W-1:2*W], eC);
    check(seenOp == opc, "R8", {name, ": latched opcode"}, seenOp, opc);
    check(relRise[0] - r0 == int'(n0), "R4", {name, ": port 0 requests"}, relRise[0] - r0, n0);
    check(relRise[1] - r1 == int'(n1), "R5", {name, ": port 1 requests"}, relRise[1] - r1, n1);
    check(relRise[2] - r2 == int'(n2), "R6", {name, ": port 2 requests"}, relRise[2] - r2, n2);
    check(wrRise - w0 == 1, "R11", {name, ": write handshakes"}, wrRise - w0, 1);
    check(accCnt - a0 == 1, "R9", {name, ": execution starts"}, accCnt - a0, 1);
    rdMask = '0;
    @(negedge clk);
    check(busy == 1'b0, "R1", {name, ": no queued issue"}, busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R12", "busy after reset", busy, 0);
    check(rdRel == '0, "R12", "rdRel after reset", rdRel, 0);
    check(wrRel == 1'b0, "R12", "wrRel after reset", wrRel, 0);
    check(exInValid == 1'b0, "R12", "exInValid after reset", exInValid, 0);

    // R3: basic, staggered grants, registered unit
    runOp("basic", 16'd5, 16'd2, 16'd1, 7'd3, 0, 16'd0, 0, 0, 3'b000, 0, 2, 1, 0, 0, 0);
    // R3 R10: reversed order, combinational unit
    runOp("reverse", 16'd9, 16'd4, 16'd7, 7'd4, 0, 16'd0, 0, 0, 3'b000, 2, 1, 0, 2, 1, 0);
    // R7: invert A, simultaneous grants
    runOp("invert", 16'd5, 16'd2, 16'd0, 7'd5, 1, 16'd0, 0, 0, 3'b000, 1, 1, 1, 1, 0, 0);
    // R4 R5: zero-A and immediate
    runOp("zero_imm", 16'd5, 16'd2, 16'd3, 7'd6, 0, 16'd8, 1, 1, 3'b000, 0, 0, 2, 0, 0, 0);
    // R6: mask ports 0 and 2, immediate on B
    runOp("mask_ac", 16'd5, 16'd2, 16'd3, 7'd7, 0, 16'd8, 1, 0, 3'b101, 0, 0, 0, 1, 0, 0);
    // R6: everything masked, combinational unit
    runOp("mask_all", 16'd5, 16'd2, 16'd3, 7'd8, 0, 16'd8, 1, 0, 3'b111, 0, 0, 0, 0, 1, 0);
    // R6: mask port 1 only
    runOp("mask_b", 16'd4, 16'd9, 16'd1, 7'd9, 0, 16'd0, 0, 0, 3'b010, 1, 0, 0, 0, 0, 0);
    // R1 R11: issue while busy is ignored
    runOp("busy_issue", 16'd1, 16'd2, 16'd3, 7'd10, 0, 16'd0, 0, 0, 3'b000, 3, 2, 4, 1, 0, 1);
    // R10 R11: combinational unit, zero-delay everywhere
    runOp("comb_zero", 16'd100, 16'd200, 16'd300, 7'd11, 0, 16'd0, 0, 0, 3'b000, 0, 0, 0, 0, 1, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule